// File: doc/BRIEF.md
# Bit-Serial Adder with Sequencing Control

This block adds two unsigned W-bit words one bit position per clock. An accumulator register holds the first operand and ends up holding the sum. An addend register holds the second operand and rotates as the bits are consumed, so it returns to its loaded value when the operation ends. A carry flip-flop passes the carry from one bit position to the next. A small controller turns a start request into exactly W shift cycles. It then signals completion and returns to idle.

The sequencing control runs on the rising clock edge. The accumulator, the addend and the carry all change on the falling edge. Each falling edge inside a shift cycle takes the full-adder sum of the two low bits and the stored carry. That sum bit enters the top of the accumulator while the accumulator moves one place toward its low end. Loading the accumulator clears the carry. Loading only the addend keeps the carry. This lets a second operation add a new word on top of the previous sum with the earlier carry as carry-in, which chains words into a wider addition. Start may be a one-cycle pulse, or it may be held high. If it is held, the controller waits in a hold state after the last shift and does not begin again until start drops.

Top module: `bit_serial_adder`

## Requirements
- R1: While reset is asserted, and just after it is released, `acc_q`, `add_q` and `carry_q` are zero, `idle` is 1 and `done` is 0.
- R2: While idle, `load_acc` copies `acc_in` into the accumulator and clears the carry, and `load_add` copies `add_in` into the addend register. Each change appears at the outputs after the next falling clock edge.
- R3: When an operation on loaded words a and b finishes, `acc_q` equals (a+b) mod 2^W and `carry_q` equals bit W of a+b.
- R4: When `done` is 1, `add_q` equals the value it held when the operation started.
- R5: A start seen while idle gives exactly W shift cycles. `idle` is 0 and `done` is 0 on the first W-1 rising edges after the start edge.
- R6: `done` is 1 for exactly one cycle. It rises on the W-th rising edge after the start edge, and by then the final sum is already present.
- R7: If start is still high when the last shift ends, the controller stays busy (`idle` 0) with no further shifts or `done` pulses, and returns to idle on the first rising edge at which start is low.
- R8: Load requests made during shift cycles are ignored, and the result is the same as without them.
- R9: Reloading only the addend keeps the stored carry, so the next operation yields (acc + add + carry) mod 2^W with its carry out in `carry_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; control on rising edge, data on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an addition |
| load_acc | input | 1 | Parallel load of the accumulator (clears carry) |
| load_add | input | 1 | Parallel load of the addend register |
| acc_in | input | W | Accumulator load value |
| add_in | input | W | Addend load value |
| acc_q | output | W | Accumulator contents, the sum after an operation |
| add_q | output | W | Addend register contents |
| carry_q | output | 1 | Stored carry, the final carry after an operation |
| done | output | 1 | One-cycle completion pulse |
| idle | output | 1 | Controller is waiting for a start |

## Verification
A wrong shift count or a lost carry appears on `acc_q` and `carry_q` at the `done` pulse of that same operation. The addend rotation is checked as well: if it stops short or overshoots, `add_q` shows a rotated copy of its loaded value at that moment instead of the value itself. A controller state fault shows up at the ports within a cycle of the expected edge. It appears as `done` too early, too late or held high, or as `idle` returning while start is still held. A carry that leaks across loads shows up in the result of the next chained operation.

// File: rtl/bit_serial_adder.sv
module bit_serial_adder #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         load_acc,
  input  logic         load_add,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] add_in,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] add_q,
  output logic         carry_q,
  output logic         done,
  output logic         idle
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_HOLD = 2'd2} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic          done_r;
  logic          shift_en;
  logic          holding;
  logic          last;

  logic [W-1:0] acc, add;
  logic         cy;
  logic         s_bit, c_bit;
  logic [W:0]   acc_ext, add_ext;

  assign shift_en = (st == ST_RUN);
  assign holding  = (st == ST_HOLD);
  assign last     = (cnt == CW'(W - 1));

  assign s_bit   = acc[0] ^ add[0] ^ cy;
  assign c_bit   = (acc[0] & add[0]) | (cy & (acc[0] ^ add[0]));
  assign acc_ext = {s_bit, acc};
  assign add_ext = {add[0], add};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st  <= ST_RUN;
          cnt <= '0;
        end
        ST_RUN: if (last) begin
          done_r <= 1'b1;
          st     <= start ? ST_HOLD : ST_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_HOLD: if (!start) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      add <= '0;
      cy  <= 1'b0;
    end else if (shift_en) begin
      acc <= acc_ext[W:1];
      add <= add_ext[W:1];
      cy  <= c_bit;
    end else begin
      if (load_acc) begin
        acc <= acc_in;
        cy  <= 1'b0;
      end
      if (load_add) add <= add_in;
    end
  end

  assign acc_q   = acc;
  assign add_q   = add;
  assign carry_q = cy;
  assign done    = done_r;
  assign idle    = (st == ST_IDLE);
endmodule

// File: rtl/bit_serial_adder_chk.sv
module bit_serial_adder_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic         idle,
  input logic         shift_en,
  input logic         holding,
  input logic [W-1:0] add_q
);
  localparam int RW = $clog2(W + 1) + 1;

  logic [RW-1:0] run;
  logic [W-1:0]  snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= '0;
      snap <= '0;
    end else begin
      run <= shift_en ? run + 1'b1 : '0;
      if (idle) snap <= add_q;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  shift_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run == RW'(W));

  // R5
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_en) |-> done);

  // R4
  addend_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> add_q == snap);

  // R7
  hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && start) |=> (holding && !done));

  // R7
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !start) |=> idle);
endmodule

bind bit_serial_adder bit_serial_adder_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .idle     (idle),
  .shift_en (shift_en),
  .holding  (holding),
  .add_q    (add_q)
);

// File: tb/bit_serial_adder_tb.sv
module bit_serial_adder_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         load_acc = 1'b0;
  logic         load_add = 1'b0;
  logic [W-1:0] acc_in = '0;
  logic [W-1:0] add_in = '0;
  logic [W-1:0] acc_q, add_q;
  logic         carry_q, done, idle;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bit_serial_adder #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load_acc(load_acc), .load_add(load_add),
    .acc_in(acc_in), .add_in(add_in),
    .acc_q(acc_q), .add_q(add_q), .carry_q(carry_q),
    .done(done), .idle(idle)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic load(input int a, input int b, input bit do_a, input bit do_b);
    acc_in   = W'(a);
    add_in   = W'(b);
    load_acc = do_a;
    load_add = do_b;
    step();
    load_acc = 1'b0;
    load_add = 1'b0;
  endtask

  task automatic run_op(input bit hold, input bit poke);
    start = 1'b1;
    step();
    if (!hold) start = 1'b0;
    for (int i = 1; i <= W; i++) begin
      if (poke) begin
        load_acc = 1'b1;
        load_add = 1'b1;
        acc_in   = '1;
        add_in   = '1;
      end
      step();
      if (i < W) begin
        check("R5 busy while shifting", int'(idle), 0);
        check("R5 no early done", int'(done), 0);
      end else begin
        check("R6 done after last shift", int'(done), 1);
        check("R7 idle at done", int'(idle), hold ? 0 : 1);
      end
    end
    load_acc = 1'b0;
    load_add = 1'b0;
    if (hold) begin
      for (int k = 0; k < 3; k++) begin
        step();
        check("R7 waits while start held", int'(idle), 0);
        check("R6 single done pulse", int'(done), 0);
      end
      start = 1'b0;
      step();
      check("R7 idle after start drops", int'(idle), 1);
    end else begin
      step();
      check("R6 single done pulse", int'(done), 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp_sum, s0, cin;
    repeat (3) @(posedge clk);
    #2;
    check("R1 acc reset", int'(acc_q), 0);
    check("R1 add reset", int'(add_q), 0);
    check("R1 carry reset", int'(carry_q), 0);
    check("R1 idle reset", int'(idle), 1);
    check("R1 done reset", int'(done), 0);
    rst_n = 1'b1;
    step();
    check("R1 idle after release", int'(idle), 1);
    check("R1 done after release", int'(done), 0);

    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        load(a, b, 1'b1, 1'b1);
        check("R2 acc load", int'(acc_q), a);
        check("R2 add load", int'(add_q), b);
        check("R2 carry cleared by acc load", int'(carry_q), 0);
        run_op(a == b, (a[0] ^ b[0]) == 1'b1);
        exp_sum = a + b;
        if (a[0] ^ b[0]) begin
          check("R8 sum with ignored loads", int'(acc_q), exp_sum % (1 << W));
          check("R8 addend with ignored loads", int'(add_q), b);
        end
        check("R3 sum", int'(acc_q), exp_sum % (1 << W));
        check("R3 carry out", int'(carry_q), exp_sum >> W);
        check("R4 addend restored", int'(add_q), b);
      end
    end

    for (int c = 0; c < (1 << W); c++) begin
      load(15, 9, 1'b1, 1'b1);
      run_op(1'b0, 1'b0);
      s0  = (15 + 9) % (1 << W);
      cin = (15 + 9) >> W;
      check("R3 chain first sum", int'(acc_q), s0);
      load(0, c, 1'b0, 1'b1);
      check("R9 carry kept on addend load", int'(carry_q), cin);
      check("R9 acc kept on addend load", int'(acc_q), s0);
      run_op(1'b0, 1'b0);
      exp_sum = s0 + c + cin;
      check("R9 chained sum", int'(acc_q), exp_sum % (1 << W));
      check("R9 chained carry", int'(carry_q), exp_sum >> W);
    end

    load(15, 1, 1'b1, 1'b1);
    run_op(1'b0, 1'b0);
    check("R3 carry set", int'(carry_q), 1);
    load(3, 0, 1'b1, 1'b0);
    check("R2 carry cleared on acc reload", int'(carry_q), 0);
    check("R2 addend untouched by acc load", int'(add_q), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule